// File: doc/BRIEF.md
# Multi-Level Block Reset Controller

This block is the control shell of a peripheral function. A small register interface gives firmware a control register with a run bit, interrupt enables and per-source masks. It also gives a status register, a small FIFO-style data channel fed by register writes, and a command register that triggers graded resets. While the run bit is set, the block takes one entry from the channel every cycle and advances an operation counter. The counter stands in for the real datapath.

The reset levels clear different classes of storage. Hard returns everything to the power-on state. Soft stops the block and clears data and status but keeps the control settings. Stop only drops the run bit. Flush rewinds the channel pointers. Empty also wipes the channel contents. An overflow or an external fault stops the block on its own and latches a flag, so firmware finds the state exactly as it was. A debug bit maps the counter and the channel pointers over the status and data addresses so they can be read and loaded. Reset values are chosen so that firmware only has to set the top-level interrupt enable for basic use.

Top module: `blkrst_top`

## Requirements
- R1: After the asynchronous reset pin: CTRL (address 0) reads 0x000C, STATUS (address 2) reads 0x0004, the counter is 0 and irq is low. CTRL holds run in bit0, top-level irq enable in bit1, overflow mask in bit2 and fault mask in bit3.
- R2: irq equals the top-level enable ANDed with the OR of (overflow flag AND bit2) and (fault flag AND bit3). With the reset masks, setting only bit1 is enough to receive interrupts.
- R3: Outside debug mode, a write to address 3 pushes its low 8 bits into a 4-entry channel, and a read of address 3 shows the head entry. While run is set and the channel is not empty, one entry is popped and the counter rises by one each cycle. STATUS holds empty in bit2, full in bit3 and the entry count in bits 6:4. A push while full is dropped.
- R4: A push while full sets the overflow flag (STATUS bit0), and a high fault_in sets the fault flag (bit1). Either event clears run at the same edge without advancing the counter.
- R5: Writing 1 to STATUS bit0 or bit1 clears that flag. Setting run again resumes counting from the frozen counter value.
- R6: Command bit2 (stop) clears only run. The counter, channel and other CTRL bits are unchanged.
- R7: Command bit1 (soft) clears run, the counter, the flags and the channel pointers and contents. It keeps CTRL bits 3:1 and the debug bit.
- R8: Command bit0 (hard) returns every register, including the debug bit and the channel contents, to the power-on values of R1.
- R9: If several command bits are written together, hard beats soft and soft beats stop. Empty (bit4) beats flush (bit3).
- R10: Flush zeroes the channel pointers and count but keeps the stored data and the flags, so the head read returns the old first slot.
- R11: Empty zeroes the pointers and count, wipes the stored data to 0 and clears the overflow flag. It keeps CTRL.
- R12: With bit0 of address 4 set, address 2 reads and writes the 16-bit counter. Address 3 reads and writes {rptr[6:5], wptr[4:3], count[2:0]}, and writes there do not push.
- R13: The reset pin acts at once, whatever the register settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous chip reset, active low, never maskable |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register word address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for bus_addr (combinational) |
| fault_in | input | 1 | External exception event |
| irq | output | 1 | Interrupt request |

## Verification
Assertions check on every cycle that an exception stops the block and latches a flag, and that stop freezes the counter and channel. They also check that soft keeps the control fields, that hard restores the defaults, that irq never rises with the top-level enable off, that the counter steps by exactly one per pop, and that the channel never counts past its depth. Only the bench scenarios can show the priority between combined commands and the data difference between flush and empty. The same holds for resuming from a frozen count, the debug overlay's load paths and the immediate effect of the reset pin.

// File: rtl/blkrst_pkg.sv
package blkrst_pkg;
  localparam logic [2:0] A_CTRL = 3'd0;
  localparam logic [2:0] A_CMD  = 3'd1;
  localparam logic [2:0] A_STAT = 3'd2;
  localparam logic [2:0] A_DATA = 3'd3;
  localparam logic [2:0] A_DBG  = 3'd4;

  localparam int CMD_HARD  = 0;
  localparam int CMD_SOFT  = 1;
  localparam int CMD_STOP  = 2;
  localparam int CMD_FLUSH = 3;
  localparam int CMD_EMPTY = 4;

  // control defaults: run off, top irq off, both source masks on
  localparam logic [3:0] CTRL_DEFAULT = 4'b1100;

  typedef enum logic [1:0] {LVL_NONE, LVL_STOP, LVL_SOFT, LVL_HARD} level_e;
  typedef enum logic [1:0] {CH_KEEP, CH_FLUSH, CH_WIPE} chan_e;

  function automatic level_e pick_level(input logic [4:0] c);
    if (c[CMD_HARD])      return LVL_HARD;
    else if (c[CMD_SOFT]) return LVL_SOFT;
    else if (c[CMD_STOP]) return LVL_STOP;
    else                  return LVL_NONE;
  endfunction

  function automatic chan_e pick_chan(input logic [4:0] c);
    if (c[CMD_EMPTY])      return CH_WIPE;
    else if (c[CMD_FLUSH]) return CH_FLUSH;
    else                   return CH_KEEP;
  endfunction

  function automatic int unsigned wrap_inc(input int unsigned p, input int unsigned lim);
    return (p + 1 == lim) ? 0 : p + 1;
  endfunction
endpackage

// File: rtl/blkrst_cmd_dec.sv
module blkrst_cmd_dec
  import blkrst_pkg::*;
(
  input  logic       cmd_wr,
  input  logic [4:0] cmd,
  output logic       do_hard,
  output logic       do_soft,
  output logic       do_stop,
  output logic       do_flush,
  output logic       do_wipe
);
  level_e lvl;
  chan_e  chs;

  always_comb begin
    lvl = cmd_wr ? pick_level(cmd) : LVL_NONE;
    chs = cmd_wr ? pick_chan(cmd) : CH_KEEP;
  end

  assign do_hard  = (lvl == LVL_HARD);
  assign do_soft  = (lvl == LVL_SOFT);
  assign do_stop  = (lvl == LVL_STOP);
  assign do_flush = (chs == CH_FLUSH);
  assign do_wipe  = (chs == CH_WIPE);
endmodule

// File: rtl/blkrst_chan.sv
module blkrst_chan
  import blkrst_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  localparam int PW   = $clog2(DEPTH),
  localparam int CNTW = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr_ptr,
  input  logic            clr_mem,
  input  logic            push,
  input  logic [DW-1:0]   push_data,
  input  logic            pop,
  input  logic            load,
  input  logic [PW-1:0]   load_rptr,
  input  logic [PW-1:0]   load_wptr,
  input  logic [CNTW-1:0] load_cnt,
  output logic [DW-1:0]   head,
  output logic [PW-1:0]   rptr,
  output logic [PW-1:0]   wptr,
  output logic [CNTW-1:0] count,
  output logic            empty,
  output logic            full
);
  logic [DW-1:0] mem [DEPTH];
  logic push_ok, pop_ok;

  assign empty   = (count == '0);
  assign full    = (count == CNTW'(DEPTH));
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (clr_ptr) begin
      rptr  <= '0;
      wptr  <= '0;
      count <= '0;
    end else if (load) begin
      rptr  <= load_rptr;
      wptr  <= load_wptr;
      count <= load_cnt;
    end else begin
      if (push_ok) wptr <= PW'(wrap_inc(int'(wptr), DEPTH));
      if (pop_ok)  rptr <= PW'(wrap_inc(int'(rptr), DEPTH));
      count <= count + CNTW'(push_ok) - CNTW'(pop_ok);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (clr_mem) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (push_ok && !clr_ptr && !load) begin
      mem[wptr] <= push_data;
    end
  end

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNTW'(DEPTH));
  p_full_drop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop && !clr_ptr && !load) |=> (count == CNTW'(DEPTH)));
endmodule

// File: rtl/blkrst_top.sv
module blkrst_top
  import blkrst_pkg::*;
#(
  parameter int DW    = 8,
  parameter int DEPTH = 4,
  parameter int BW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [2:0]    bus_addr,
  input  logic [BW-1:0] bus_wdata,
  output logic [BW-1:0] bus_rdata,
  input  logic          fault_in,
  output logic          irq
);
  localparam int PW   = $clog2(DEPTH);
  localparam int CNTW = $clog2(DEPTH + 1);

  // control and status storage
  logic go, top_en, en_ovf, en_ext, dbg;
  logic ovf_flag, ext_flag;
  logic [BW-1:0] op_cnt;

  // channel view
  logic [DW-1:0]   head;
  logic [PW-1:0]   rptr, wptr;
  logic [CNTW-1:0] count;
  logic            empty, full;

  // named internal events
  logic wr_ctrl, wr_cmd, wr_stat, wr_cnt, wr_data, wr_ptrs, wr_dbg;
  logic do_hard, do_soft, do_stop, do_flush, do_wipe;
  logic ovf_evt, ext_evt, exc_evt, halt_evt, step;

  assign wr_ctrl = bus_wr && (bus_addr == A_CTRL);
  assign wr_cmd  = bus_wr && (bus_addr == A_CMD);
  assign wr_stat = bus_wr && (bus_addr == A_STAT) && !dbg;
  assign wr_cnt  = bus_wr && (bus_addr == A_STAT) && dbg;
  assign wr_data = bus_wr && (bus_addr == A_DATA) && !dbg;
  assign wr_ptrs = bus_wr && (bus_addr == A_DATA) && dbg;
  assign wr_dbg  = bus_wr && (bus_addr == A_DBG);

  blkrst_cmd_dec u_dec (
    .cmd_wr   (wr_cmd),
    .cmd      (bus_wdata[4:0]),
    .do_hard  (do_hard),
    .do_soft  (do_soft),
    .do_stop  (do_stop),
    .do_flush (do_flush),
    .do_wipe  (do_wipe)
  );

  assign ovf_evt  = wr_data && full;
  assign ext_evt  = fault_in;
  assign exc_evt  = ovf_evt || ext_evt;
  assign halt_evt = do_hard || do_soft || do_stop || exc_evt;
  assign step     = go && !empty && !halt_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_ext, en_ovf, top_en, go} <= CTRL_DEFAULT;
      dbg <= 1'b0;
    end else if (do_hard) begin
      {en_ext, en_ovf, top_en, go} <= CTRL_DEFAULT;
      dbg <= 1'b0;
    end else begin
      if (wr_ctrl) {en_ext, en_ovf, top_en, go} <= bus_wdata[3:0];
      if (wr_dbg)  dbg <= bus_wdata[0];
      if (halt_evt) go <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else if (do_hard || do_soft) begin
      ovf_flag <= 1'b0;
      ext_flag <= 1'b0;
    end else begin
      ovf_flag <= ovf_evt || (ovf_flag && !(wr_stat && bus_wdata[0]) && !do_wipe);
      ext_flag <= ext_evt || (ext_flag && !(wr_stat && bus_wdata[1]));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  op_cnt <= '0;
    else if (do_hard || do_soft) op_cnt <= '0;
    else if (wr_cnt)             op_cnt <= bus_wdata;
    else if (step)               op_cnt <= op_cnt + 1'b1;
  end

  blkrst_chan #(.DW(DW), .DEPTH(DEPTH)) u_chan (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr_ptr   (do_hard || do_soft || do_flush || do_wipe),
    .clr_mem   (do_hard || do_soft || do_wipe),
    .push      (wr_data),
    .push_data (bus_wdata[DW-1:0]),
    .pop       (step),
    .load      (wr_ptrs),
    .load_rptr (bus_wdata[CNTW+PW +: PW]),
    .load_wptr (bus_wdata[CNTW +: PW]),
    .load_cnt  (bus_wdata[CNTW-1:0]),
    .head      (head),
    .rptr      (rptr),
    .wptr      (wptr),
    .count     (count),
    .empty     (empty),
    .full      (full)
  );

  assign irq = top_en && ((ovf_flag && en_ovf) || (ext_flag && en_ext));

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_CTRL: bus_rdata[3:0] = {en_ext, en_ovf, top_en, go};
      A_STAT: begin
        if (dbg) bus_rdata = op_cnt;
        else begin
          bus_rdata[0] = ovf_flag;
          bus_rdata[1] = ext_flag;
          bus_rdata[2] = empty;
          bus_rdata[3] = full;
          bus_rdata[4 +: CNTW] = count;
        end
      end
      A_DATA: begin
        if (dbg) begin
          bus_rdata[CNTW-1:0]     = count;
          bus_rdata[CNTW +: PW]    = wptr;
          bus_rdata[CNTW+PW +: PW] = rptr;
        end else bus_rdata[DW-1:0] = head;
      end
      A_DBG:   bus_rdata[0] = dbg;
      default: bus_rdata = '0;
    endcase
  end

  p_irq_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !top_en |-> !irq);
  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (op_cnt == $past(op_cnt) + 1'b1));
  p_exc_halt_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt && !do_hard && !do_soft) |=> (!go && (ovf_flag || ext_flag)));
  p_exc_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (exc_evt && !wr_cnt && !do_hard && !do_soft) |=> $stable(op_cnt));
  p_stop_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
    do_stop |=> (!go && $stable(op_cnt) && $stable(count) && $stable({top_en, en_ovf, en_ext, dbg})));
  p_soft_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    do_soft |=> (op_cnt == '0 && empty && !ovf_flag && !ext_flag && $stable({top_en, en_ovf, en_ext, dbg})));
  p_hard_dflt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    do_hard |=> ({en_ext, en_ovf, top_en, go} == CTRL_DEFAULT && !dbg && op_cnt == '0 && empty));
endmodule

// File: tb/tb_blkrst_top.sv
module tb_blkrst_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [15:0] bus_wdata = '0;
  logic [15:0] bus_rdata;
  logic        fault_in = 1'b0;
  logic        irq;

  int n_chk = 0;
  int n_err = 0;

  blkrst_top dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .fault_in(fault_in), .irq(irq)
  );

  always #5 clk = ~clk;

  // row: [40] read, [39:37] addr, [36:21] data, [20:5] expected, [4] irq, [3:0] requirement
  function automatic logic [40:0] f_w(input logic [2:0] a, input logic [15:0] d);
    return {1'b0, a, d, 16'h0, 1'b0, 4'd0};
  endfunction
  function automatic logic [40:0] f_r(input logic [2:0] a, input logic [15:0] e,
                                      input logic i, input logic [3:0] r);
    return {1'b1, a, 16'h0, e, i, r};
  endfunction

  localparam int NT = 29;
  localparam logic [40:0] TBL [NT] = '{
    f_r(3'd0, 16'h000C, 1'b0, 4'd1),  // R1 control defaults
    f_r(3'd2, 16'h0004, 1'b0, 4'd1),  // R1 status empty
    f_w(3'd3, 16'h0011), f_w(3'd3, 16'h0022),
    f_r(3'd2, 16'h0020, 1'b0, 4'd3),  // R3 two entries
    f_r(3'd3, 16'h0011, 1'b0, 4'd3),  // R3 head
    f_w(3'd3, 16'h0033), f_w(3'd3, 16'h0044),
    f_r(3'd2, 16'h0048, 1'b0, 4'd3),  // R3 full
    f_w(3'd3, 16'h0055),
    f_r(3'd2, 16'h0049, 1'b0, 4'd4),  // R4 overflow flag
    f_r(3'd3, 16'h0011, 1'b0, 4'd3),  // R3 dropped push
    f_w(3'd0, 16'h000E),
    f_r(3'd0, 16'h000E, 1'b1, 4'd2),  // R2 top enable alone
    f_w(3'd2, 16'h0001),
    f_r(3'd2, 16'h0048, 1'b0, 4'd5),  // R5 clear flag
    f_w(3'd1, 16'h0008),
    f_r(3'd2, 16'h0004, 1'b0, 4'd10), // R10 flushed
    f_r(3'd3, 16'h0011, 1'b0, 4'd10), // R10 data kept
    f_w(3'd3, 16'h0001), f_w(3'd3, 16'h0002), f_w(3'd3, 16'h0003),
    f_w(3'd3, 16'h0004), f_w(3'd3, 16'h0005),
    f_r(3'd2, 16'h0049, 1'b1, 4'd4),  // R4 overflow again
    f_w(3'd1, 16'h0010),
    f_r(3'd2, 16'h0004, 1'b0, 4'd11), // R11 flag cleared
    f_r(3'd3, 16'h0000, 1'b0, 4'd11), // R11 data wiped
    f_r(3'd0, 16'h000E, 1'b0, 4'd11)  // R11 control kept
  };

  task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [15:0] exp, input string tag);
    bus_addr = a; #1;
    chk(tag, bus_rdata, exp);
  endtask

  task automatic pulse_fault();
    fault_in = 1'b1;
    @(negedge clk); #1;
    fault_in = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    chk("R1 irq", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'h0001);
    rd(3'd2, 16'h0000, "R1 counter");
    wr(3'd4, 16'h0000);

    for (int i = 0; i < NT; i++) begin
      if (TBL[i][40]) begin
        rd(TBL[i][39:37], TBL[i][20:5], $sformatf("R%0d table row %0d", TBL[i][3:0], i));
        chk($sformatf("R%0d irq row %0d", TBL[i][3:0], i), {15'b0, irq}, {15'b0, TBL[i][4]});
      end else begin
        wr(TBL[i][39:37], TBL[i][36:21]);
      end
    end

    // R3: run drains three entries
    wr(3'd3, 16'h00AA); wr(3'd3, 16'h00BB); wr(3'd3, 16'h00CC);
    wr(3'd0, 16'h000D);
    idle(6);
    rd(3'd2, 16'h0004, "R3 drained");
    wr(3'd4, 16'h0001);
    rd(3'd2, 16'h0003, "R3 counter");
    wr(3'd4, 16'h0000);

    // R4: fault freezes counter and channel
    wr(3'd0, 16'h000C);
    wr(3'd3, 16'h0001); wr(3'd3, 16'h0002);
    wr(3'd0, 16'h000D);
    pulse_fault();
    rd(3'd0, 16'h000C, "R4 run cleared");
    rd(3'd2, 16'h0022, "R4 fault flag");
    wr(3'd4, 16'h0001);
    rd(3'd2, 16'h0003, "R4 counter frozen");
    wr(3'd4, 16'h0000);

    // R5: clear and resume
    wr(3'd2, 16'h0002);
    rd(3'd2, 16'h0020, "R5 w1c");
    wr(3'd0, 16'h000D);
    idle(4);
    rd(3'd2, 16'h0004, "R5 resumed drain");
    wr(3'd4, 16'h0001);
    rd(3'd2, 16'h0005, "R5 counter resumed");
    wr(3'd4, 16'h0000);

    // R2: per-source mask
    wr(3'd0, 16'h0006);
    pulse_fault();
    chk("R2 masked source", {15'b0, irq}, 16'h0);
    rd(3'd2, 16'h0006, "R2 flag still set");
    wr(3'd0, 16'h000E);
    chk("R2 source enabled", {15'b0, irq}, 16'h1);
    wr(3'd2, 16'h0002);
    chk("R2 cleared", {15'b0, irq}, 16'h0);

    // R6: soft stop
    wr(3'd3, 16'h0001); wr(3'd3, 16'h0002); wr(3'd3, 16'h0003); wr(3'd3, 16'h0004);
    wr(3'd0, 16'h000F);
    wr(3'd1, 16'h0004);
    rd(3'd0, 16'h000E, "R6 only run cleared");
    rd(3'd2, 16'h0048, "R6 channel kept");
    wr(3'd4, 16'h0001);
    rd(3'd2, 16'h0005, "R6 counter kept");
    wr(3'd4, 16'h0000);

    // R7: soft reset
    pulse_fault();
    chk("R7 irq before", {15'b0, irq}, 16'h1);
    wr(3'd4, 16'h0001);
    wr(3'd1, 16'h0002);
    rd(3'd4, 16'h0001, "R7 debug kept");
    rd(3'd2, 16'h0000, "R7 counter cleared");
    rd(3'd3, 16'h0000, "R7 pointers cleared");
    chk("R7 irq after", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'h0000);
    rd(3'd2, 16'h0004, "R7 status cleared");
    rd(3'd0, 16'h000E, "R7 control kept");
    rd(3'd3, 16'h0000, "R7 data wiped");

    // R9: priorities
    wr(3'd3, 16'h005A);
    wr(3'd1, 16'h0006);
    rd(3'd2, 16'h0004, "R9 soft over stop");
    rd(3'd3, 16'h0000, "R9 soft over stop data");
    wr(3'd1, 16'h0003);
    rd(3'd0, 16'h000C, "R9 hard over soft");
    wr(3'd3, 16'h0077);
    wr(3'd1, 16'h0018);
    rd(3'd3, 16'h0000, "R9 empty over flush");
    rd(3'd2, 16'h0004, "R9 empty over flush status");

    // R12 and R8: debug counter load, then hard reset
    wr(3'd0, 16'h000F);
    wr(3'd4, 16'h0001);
    wr(3'd2, 16'h1234);
    rd(3'd2, 16'h1234, "R12 counter load");
    wr(3'd1, 16'h0001);
    rd(3'd4, 16'h0000, "R8 debug cleared");
    rd(3'd0, 16'h000C, "R8 control default");
    rd(3'd2, 16'h0004, "R8 status default");
    chk("R8 irq", {15'b0, irq}, 16'h0);
    wr(3'd4, 16'h0001);
    rd(3'd2, 16'h0000, "R8 counter cleared");
    wr(3'd3, 16'h003A);
    rd(3'd3, 16'h003A, "R12 pointer load");
    wr(3'd4, 16'h0000);
    rd(3'd2, 16'h0020, "R12 no push in debug");

    // R13: asynchronous reset pin
    wr(3'd0, 16'h000E);
    pulse_fault();
    chk("R13 irq before", {15'b0, irq}, 16'h1);
    #2 rst_n = 1'b0;
    bus_addr = 3'd0; #1;
    chk("R13 control", bus_rdata, 16'h000C);
    chk("R13 irq", {15'b0, irq}, 16'h0);
    @(negedge clk); #1 rst_n = 1'b1;
    rd(3'd2, 16'h0004, "R13 status");

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule